// File: doc/BRIEF.md
# Synchronous Buck Switch Sequencer

This block decides, cycle by cycle, when the high-side and low-side switch enables of a synchronous step-down stage are raised and lowered. A cycle-start pulse from the oscillator arms the high-side switch. The high-side pulse ends on a PWM comparator trip, on a current-limit trip or on a maximum-duty pulse. After a programmable gap with both switches off, the low-side (rectifier) switch conducts until the inductor-current condition for the active mode ends it, or until the next cycle begins. All analog comparators arrive as single-bit flags that are synchronous to the system clock.

Two operating modes are provided. In fixed-frequency mode, the minimum-peak-current flag is ignored. The rectifier stays on until the next cycle start and turns off early only if the reverse-current limit trips, so the inductor current may go negative. In pulse-skipping mode, a pulse may end on the PWM comparator only after the peak current has reached its minimum level. The rectifier opens when the inductor current crosses zero. A cycle start that arrives while the PWM trip is already set is dropped. Two protection inputs override the sequencing: a force-off input and a crowbar input that holds the low-side switch on.

Top module: `buck_switch_seq`

## Requirements
- R1: While reset is high, and on the first cycle after it, both enables are low.
- R2: When the stage has been idle with both switches off for at least DEAD_CYC cycles, a cycle start that is not skipped raises hs_en on the following clock cycle.
- R3: In either mode, ilim_trip or max_duty while hs_en is high lowers hs_en on the next cycle, whatever the level of imin_reached.
- R4: In fixed mode (fixed_freq=1), pwm_trip alone ends the high-side pulse. In skip mode (fixed_freq=0), pwm_trip ends it only when imin_reached is also high.
- R5: After either switch turns off, both enables stay low for exactly DEAD_CYC cycles before the other switch turns on. A start that comes from idle before DEAD_CYC off cycles have passed is held off until that count is complete.
- R6: hs_en and ls_en are never high in the same cycle.
- R7: In fixed mode, ls_en stays high until a cycle start arrives or irev_limit is seen. izero_cross has no effect on it.
- R8: In skip mode, izero_cross lowers ls_en on the next cycle. irev_limit has no effect.
- R9: In skip mode, a cycle start that arrives with pwm_trip already high is ignored: hs_en stays low and a conducting low-side switch stays on. In fixed mode, no cycle is skipped.
- R10: force_off, when force_crowbar is low, lowers both enables on the next cycle and keeps them low, ignoring cycle starts.
- R11: force_crowbar holds hs_en low. It raises ls_en after the DEAD_CYC gap, or keeps it high if it is already high, and ignores every other input, force_off included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_start | input | 1 | One-cycle pulse at each oscillator cycle start |
| pwm_trip | input | 1 | PWM comparator has tripped |
| ilim_trip | input | 1 | Positive current limit reached |
| imin_reached | input | 1 | Peak current has reached the skip-mode minimum |
| izero_cross | input | 1 | Inductor current has fallen to zero |
| irev_limit | input | 1 | Reverse (negative) current limit reached |
| max_duty | input | 1 | Maximum on-time has elapsed |
| fixed_freq | input | 1 | 1 = fixed-frequency mode, 0 = pulse-skipping mode |
| force_off | input | 1 | Protection request: both switches off |
| force_crowbar | input | 1 | Protection request: low-side switch on, high-side off |
| hs_en | output | 1 | High-side switch enable |
| ls_en | output | 1 | Low-side switch enable |

## Verification
The hardest case to reach from the ports is a cycle start from idle that arrives before the off-time count has completed. The stimulus gets there by ending a low-side phase with force_off and issuing a start two cycles later. The bench then counts the remaining off cycles before hs_en rises. The crowbar entered from an active high-side pulse is also hard to reach, because its gap runs while other flags are asserted. The stimulus walks a vector table in which every row applies one input pattern for a chosen number of cycles and then compares both enables, with hs_en/ls_en overlap checked on every cycle.

// File: rtl/buck_seq_pkg.sv
package buck_seq_pkg;

    typedef enum logic [2:0] {
        ST_OFF    = 3'd0,
        ST_HS     = 3'd1,
        ST_GAP_HL = 3'd2,
        ST_LS     = 3'd3,
        ST_GAP_LH = 3'd4
    } sw_state_e;

    typedef struct packed {
        logic cyc_start;
        logic pwm_trip;
        logic ilim_trip;
        logic imin_reached;
        logic izero_cross;
        logic irev_limit;
        logic max_duty;
        logic fixed_freq;
        logic force_off;
        logic force_crowbar;
    } sense_t;

    typedef struct packed {
        logic crowbar;
        logic off;
        logic begin_hs;
        logic hs_stop;
        logic ls_stop;
    } decision_t;

    function automatic logic hs_end(input sense_t s);
        return s.ilim_trip | s.max_duty | (s.pwm_trip & (s.fixed_freq | s.imin_reached));
    endfunction

    function automatic logic ls_end(input sense_t s);
        return s.fixed_freq ? s.irev_limit : s.izero_cross;
    endfunction

    function automatic logic cycle_taken(input sense_t s);
        return s.cyc_start & ~(~s.fixed_freq & s.pwm_trip);
    endfunction

endpackage

// File: rtl/buck_seq_decide.sv
module buck_seq_decide
    import buck_seq_pkg::*;
(
    input  sense_t    sense,
    output decision_t dec
);
    always_comb begin
        dec.crowbar  = sense.force_crowbar;
        dec.off      = sense.force_off;
        dec.begin_hs = cycle_taken(sense);
        dec.hs_stop  = hs_end(sense);
        dec.ls_stop  = ls_end(sense);
    end
endmodule

// File: rtl/buck_seq_gap_timer.sv
module buck_seq_gap_timer #(
    parameter int DEAD_CYC = 12
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    output logic done
);
    localparam int CW = (DEAD_CYC < 2) ? 1 : $clog2(DEAD_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(DEAD_CYC - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt <= '0;
        else if (cnt != LAST)
            cnt <= cnt + 1'b1;
    end

    assign done = (cnt == LAST);

    assert_gap_count_bound_R5: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST);
endmodule

// File: rtl/buck_seq_fsm.sv
module buck_seq_fsm
    import buck_seq_pkg::*;
#(
    parameter int DEAD_CYC = 12
) (
    input  logic      clk,
    input  logic      rst,
    input  decision_t dec,
    output logic      hs_en,
    output logic      ls_en
);
    localparam int RW = $clog2(DEAD_CYC + 2);

    sw_state_e st, nxt;
    logic gap_done;
    logic timer_clr;

    always_comb begin
        nxt = st;
        if (dec.crowbar) begin
            unique case (st)
                ST_LS:     nxt = ST_LS;
                ST_GAP_HL: nxt = gap_done ? ST_LS : ST_GAP_HL;
                default:   nxt = ST_GAP_HL;
            endcase
        end else if (dec.off) begin
            nxt = ST_OFF;
        end else begin
            unique case (st)
                ST_OFF:    if (dec.begin_hs) nxt = gap_done ? ST_HS : ST_GAP_LH;
                ST_HS:     if (dec.hs_stop) nxt = ST_GAP_HL;
                ST_GAP_HL: if (gap_done) nxt = ST_LS;
                ST_LS: begin
                    if (dec.begin_hs)     nxt = ST_GAP_LH;
                    else if (dec.ls_stop) nxt = ST_OFF;
                end
                ST_GAP_LH: if (gap_done) nxt = ST_HS;
                default:   nxt = ST_OFF;
            endcase
        end
    end

    // leaving idle for the gap keeps the off time already counted
    assign timer_clr = (nxt != st) && !(st == ST_OFF && nxt == ST_GAP_LH);

    buck_seq_gap_timer #(.DEAD_CYC(DEAD_CYC)) i_gap (
        .clk  (clk),
        .rst  (rst),
        .clr  (timer_clr),
        .done (gap_done)
    );

    always_ff @(posedge clk) begin
        if (rst) st <= ST_OFF;
        else     st <= nxt;
    end

    assign hs_en = (st == ST_HS);
    assign ls_en = (st == ST_LS);

    // checker: consecutive cycles with both switches off
    logic [RW-1:0] off_run;
    always_ff @(posedge clk) begin
        if (rst)
            off_run <= '0;
        else if (hs_en || ls_en)
            off_run <= '0;
        else if (off_run != RW'(DEAD_CYC))
            off_run <= off_run + 1'b1;
    end

    assert_no_overlap_R6: assert property (@(posedge clk) disable iff (rst)
        !(hs_en && ls_en));
    assert_ls_gap_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(ls_en) |-> (off_run >= RW'(DEAD_CYC)));
    assert_hs_gap_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(hs_en) |-> (off_run >= RW'(DEAD_CYC)));
endmodule

// File: rtl/buck_switch_seq.sv
module buck_switch_seq
    import buck_seq_pkg::*;
#(
    parameter int DEAD_CYC = 12
) (
    input  logic clk,
    input  logic rst,
    input  logic cyc_start,
    input  logic pwm_trip,
    input  logic ilim_trip,
    input  logic imin_reached,
    input  logic izero_cross,
    input  logic irev_limit,
    input  logic max_duty,
    input  logic fixed_freq,
    input  logic force_off,
    input  logic force_crowbar,
    output logic hs_en,
    output logic ls_en
);
    sense_t    sense;
    decision_t dec;

    always_comb begin
        sense.cyc_start     = cyc_start;
        sense.pwm_trip      = pwm_trip;
        sense.ilim_trip     = ilim_trip;
        sense.imin_reached  = imin_reached;
        sense.izero_cross   = izero_cross;
        sense.irev_limit    = irev_limit;
        sense.max_duty      = max_duty;
        sense.fixed_freq    = fixed_freq;
        sense.force_off     = force_off;
        sense.force_crowbar = force_crowbar;
    end

    buck_seq_decide i_decide (
        .sense (sense),
        .dec   (dec)
    );

    buck_seq_fsm #(.DEAD_CYC(DEAD_CYC)) i_fsm (
        .clk   (clk),
        .rst   (rst),
        .dec   (dec),
        .hs_en (hs_en),
        .ls_en (ls_en)
    );

    assert_limit_ends_pulse_R3: assert property (@(posedge clk) disable iff (rst)
        (hs_en && (ilim_trip || max_duty) && !force_crowbar) |=> !hs_en);
    assert_min_current_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (hs_en && pwm_trip && !imin_reached && !fixed_freq && !ilim_trip && !max_duty
         && !force_off && !force_crowbar) |=> hs_en);
    assert_fixed_ls_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (ls_en && fixed_freq && !cyc_start && !irev_limit && !force_off) |=> ls_en);
    assert_skip_zero_cross_R8: assert property (@(posedge clk) disable iff (rst)
        (ls_en && !fixed_freq && izero_cross && !cyc_start && !force_crowbar) |=> !ls_en);
    assert_skip_keeps_ls_R9: assert property (@(posedge clk) disable iff (rst)
        (ls_en && !fixed_freq && cyc_start && pwm_trip && !izero_cross && !force_off) |=> ls_en);
    assert_force_off_R10: assert property (@(posedge clk) disable iff (rst)
        (force_off && !force_crowbar) |=> (!hs_en && !ls_en));
    assert_crowbar_no_hs_R11: assert property (@(posedge clk) disable iff (rst)
        force_crowbar |=> !hs_en);
    assert_crowbar_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (force_crowbar && ls_en) |=> ls_en);
endmodule

// File: tb/test_buck_switch_seq.sv
`timescale 1ns/1ps
module test_buck_switch_seq;
    localparam int DT = 12;
    localparam int NV = 50;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [9:0] drv = '0;   // {start,pwm,ilim,imin,izero,irev,maxd,fixed,foff,fcrow}
    logic hs_en, ls_en;
    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    buck_switch_seq #(.DEAD_CYC(DT)) i_buck_switch_seq (
        .clk           (clk),
        .rst           (rst),
        .cyc_start     (drv[9]),
        .pwm_trip      (drv[8]),
        .ilim_trip     (drv[7]),
        .imin_reached  (drv[6]),
        .izero_cross   (drv[5]),
        .irev_limit    (drv[4]),
        .max_duty      (drv[3]),
        .fixed_freq    (drv[2]),
        .force_off     (drv[1]),
        .force_crowbar (drv[0]),
        .hs_en         (hs_en),
        .ls_en         (ls_en)
    );

    // {cycles[4:0], inputs[9:0], exp_hs, exp_ls}
    localparam logic [16:0] VEC [NV] = '{
        {5'd1,  10'b1000000100, 2'b10},  // 0  R2 start from idle
        {5'd3,  10'b0000000100, 2'b10},  // 1  R2
        {5'd1,  10'b0100000100, 2'b00},  // 2  R4 fixed pwm ends pulse
        {5'd11, 10'b0000000100, 2'b00},  // 3  R5 gap
        {5'd1,  10'b0000000100, 2'b01},  // 4  R5 ls after gap
        {5'd5,  10'b0000000100, 2'b01},  // 5  R7 hold
        {5'd1,  10'b1000000100, 2'b00},  // 6  R5
        {5'd11, 10'b0000000100, 2'b00},  // 7  R5
        {5'd1,  10'b0000000100, 2'b10},  // 8  R5
        {5'd1,  10'b0010000100, 2'b00},  // 9  R3 ilim
        {5'd12, 10'b0000000100, 2'b01},  // 10 R5
        {5'd1,  10'b0000100100, 2'b01},  // 11 R7 izero ignored
        {5'd1,  10'b0000010100, 2'b00},  // 12 R7 irev ends ls
        {5'd12, 10'b0000000100, 2'b00},  // 13 R5 idle
        {5'd1,  10'b1100000100, 2'b10},  // 14 R9 fixed never skips
        {5'd1,  10'b0100000100, 2'b00},  // 15 R4
        {5'd12, 10'b0000000100, 2'b01},  // 16 R5
        {5'd1,  10'b0000000010, 2'b00},  // 17 R10
        {5'd12, 10'b0000000000, 2'b00},  // 18 R10
        {5'd1,  10'b1100000000, 2'b00},  // 19 R9 skipped
        {5'd1,  10'b1000000000, 2'b10},  // 20 R2
        {5'd1,  10'b0100000000, 2'b10},  // 21 R4 below minimum
        {5'd1,  10'b0101000000, 2'b00},  // 22 R4 minimum reached
        {5'd12, 10'b0000000000, 2'b01},  // 23 R5
        {5'd1,  10'b0000010000, 2'b01},  // 24 R8 irev ignored
        {5'd1,  10'b1100000000, 2'b01},  // 25 R9 skip while ls
        {5'd1,  10'b0000100000, 2'b00},  // 26 R8 zero cross
        {5'd12, 10'b0000000000, 2'b00},  // 27 R8
        {5'd1,  10'b1000000000, 2'b10},  // 28 R2
        {5'd1,  10'b0000001000, 2'b00},  // 29 R3 max duty
        {5'd12, 10'b0000000000, 2'b01},  // 30 R5
        {5'd1,  10'b1000000000, 2'b00},  // 31 R5
        {5'd12, 10'b0000000000, 2'b10},  // 32 R5
        {5'd1,  10'b0010000000, 2'b00},  // 33 R3 ilim without imin
        {5'd12, 10'b0000000000, 2'b01},  // 34 R5
        {5'd1,  10'b0000000101, 2'b01},  // 35 R11
        {5'd1,  10'b1000000101, 2'b01},  // 36 R11 start ignored
        {5'd1,  10'b0000100001, 2'b01},  // 37 R11 zero cross ignored
        {5'd1,  10'b0000000011, 2'b01},  // 38 R11 beats force_off
        {5'd1,  10'b0000000010, 2'b00},  // 39 R10
        {5'd12, 10'b0000000100, 2'b00},  // 40 R10
        {5'd1,  10'b1000000100, 2'b10},  // 41 R2
        {5'd1,  10'b0000000101, 2'b00},  // 42 R11 crowbar from hs
        {5'd11, 10'b0100000101, 2'b00},  // 43 R11
        {5'd1,  10'b0000000101, 2'b01},  // 44 R11
        {5'd1,  10'b0000000010, 2'b00},  // 45 R10
        {5'd1,  10'b1000000010, 2'b00},  // 46 R10 start ignored
        {5'd1,  10'b1000000100, 2'b00},  // 47 R5 early start held
        {5'd9,  10'b0000000100, 2'b00},  // 48 R5
        {5'd1,  10'b0000000100, 2'b10}   // 49 R5
    };

    function automatic string req_of(input int i);
        case (i)
            0, 1, 20, 28, 41:                       return "R2";
            9, 29, 33:                              return "R3";
            2, 15, 21, 22:                          return "R4";
            5, 11, 12:                              return "R7";
            24, 26, 27:                             return "R8";
            14, 19, 25:                             return "R9";
            17, 18, 39, 40, 45, 46:                 return "R10";
            35, 36, 37, 38, 42, 43, 44:             return "R11";
            default:                                return "R5";
        endcase
    endfunction

    task automatic check(input string req, input logic eh, input logic el);
        checks++;
        if (hs_en !== eh || ls_en !== el) begin
            errors++;
            $display("FAIL %s: hs_en/ls_en = %b%b expected %b%b at %0t",
                     req, hs_en, ls_en, eh, el, $time);
        end
    endtask

    task automatic run_row(input int i);
        drv = VEC[i][11:2];
        for (int c = 0; c < int'(VEC[i][16:12]); c++) begin
            @(negedge clk);
            if (hs_en && ls_en) begin  // R6
                checks++;
                errors++;
                $display("FAIL R6: hs_en/ls_en = 11 expected not both at %0t", $time);
            end
        end
        check(req_of(i), VEC[i][1], VEC[i][0]);
    endtask

    initial begin
        rst = 1'b1;
        drv = '0;
        repeat (3) @(negedge clk);
        check("R1", 1'b0, 1'b0);
        rst = 1'b0;
        @(negedge clk);
        check("R1", 1'b0, 1'b0);
        repeat (15) @(negedge clk);
        for (int i = 0; i < NV; i++) run_row(i);
        // reset during a high-side pulse
        drv = '0;
        rst = 1'b1;
        @(negedge clk);
        check("R1", 1'b0, 1'b0);
        rst = 1'b0;
        @(negedge clk);
        check("R1", 1'b0, 1'b0);
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule